// File: doc/BRIEF.md
# Mixed-Mode Reseeding Scan Test Sequencer

This block sequences a logic self-test that feeds a set of scan chains from a 32-bit linear-feedback pattern generator. It walks through a schedule held in an external table. The table is read one entry at a time through an address/data pair. Each entry names one action:

- a pseudorandom pattern, which continues the generator from where it stopped;
- a deterministic pattern, where a fresh 32-bit seed is first taken bit by bit from a seed source over a valid/ready handshake;
- a generator-only burst, which advances the generator a programmed number of clocks while the chains stay still;
- the end of test.

Every pattern is shifted into the chains over a fixed number of clocks, followed by a one-clock capture. The response is unloaded during the next pattern's shift. After the last pattern, a final unload runs with the generator frozen, and the block then raises its done flag until reset. The response stream leaving the chains is only passed through to the compactor outside.

Top module: `mixbist_seq`

## Requirements
- R1: After reset is released, the block is idle: scan enable, chain clock enable, capture, seed_ready and done are low, sched_addr is 0, and the generator holds RESET_SEED, so the first pseudorandom pattern is produced from RESET_SEED.
- R2: The generator is a 32-bit Fibonacci register. scan_data is its bit 31. Each advance shifts the state one place toward bit 31 and puts into bit 0 the XOR of the state bits selected by TAP_MASK.
- R3: A pattern shift lasts exactly CHAIN_LEN consecutive cycles with scan_en and chain_clk_en high, and the generator advances once per cycle. The next cycle is a single capture cycle: capture high, scan_en low, chain_clk_en high.
- R4: A pseudorandom entry does not reload the generator: its pattern starts from the state left by whatever ran before it.
- R5: A deterministic entry raises seed_ready and accepts one seed bit on each cycle with seed_valid and seed_ready both high, most significant bit first, with no feedback. Cycles without seed_valid stall without changing the generator. The shift starts in the cycle after the 32nd bit is accepted, and its pattern is produced from the loaded seed.
- R6: seed_valid and seed_bit have no effect while seed_ready is low.
- R7: A generator-only entry with count N advances the generator exactly N times while scan_en and chain_clk_en stay low. N = 0 leaves the generator unchanged.
- R8: An entry is 18 bits. Bits [17:16] are the kind: 00 pseudorandom, 01 deterministic, 10 generator-only, 11 end. Bits [15:0] are the burst count. Entries are read in address order starting at address 0, presented on sched_addr.
- R9: On the end entry, if at least one pattern was captured, an unload of CHAIN_LEN cycles follows with scan_en and chain_clk_en high, no capture, and the generator frozen. done rises in the cycle after the unload.
- R10: done stays high until reset, with scan_en, chain_clk_en, capture and seed_ready low. An end entry at address 0 gives done without any shift.
- R11: resp_out follows chain_out combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sched_addr | output | SCHED_AW | Address of the schedule entry being read |
| sched_entry | input | 18 | Schedule entry at sched_addr (kind and count) |
| seed_valid | input | 1 | Seed bit offered |
| seed_bit | input | 1 | Seed data bit, MSB first |
| seed_ready | output | 1 | Seed load in progress, bit accepted when valid |
| scan_en | output | 1 | Scan shift enable |
| chain_clk_en | output | 1 | Scan chain clock enable |
| scan_data | output | 1 | Serial pattern into the chains |
| capture | output | 1 | One-cycle capture pulse |
| chain_out | input | 1 | Serial response from the chains |
| resp_out | output | 1 | Response passed through to the compactor |
| done | output | 1 | Test finished, held until reset |

## Verification
On every cycle, the assertions check the framing rules: the capture pulse is single, has scan enable low, and comes right after exactly CHAIN_LEN shift cycles. Shift runs never exceed CHAIN_LEN. Chains stay still while a seed loads, a stalled seed load leaves the generator untouched, and done is sticky and quiet. Other properties depend on the data and the order of the schedule, so only the bench scenarios can show them. These are the serial pattern bits matching an independent model of the generator, seeds arriving MSB first through stalls, bursts advancing the generator by exactly their count (including zero), pseudorandom entries continuing from the previous state, seed input being ignored outside a load, and the frozen final unload.

// File: rtl/mixbist_pkg.sv
// Shared types for the mixed-mode scan test sequencer.
// Assumes an 18-bit schedule entry: kind in [17:16], count in [15:0].
package mixbist_pkg;
    localparam int SEED_BITS   = 32;
    localparam int ENTRY_W     = 18;
    localparam int COUNT_FLD_W = 16;

    typedef enum logic [1:0] {
        ENT_RAND = 2'b00,
        ENT_SEED = 2'b01,
        ENT_PART = 2'b10,
        ENT_STOP = 2'b11
    } ent_kind_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_SEED,
        ST_SHIFT,
        ST_CAPT,
        ST_PART,
        ST_UNLOAD,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        PG_HOLD,
        PG_STEP,
        PG_LOAD
    } pg_op_t;
endpackage

// File: rtl/prpg_lfsr.sv
// Fibonacci pattern generator. The serial output is the top bit.
// STEP shifts toward the top bit with the XOR of the tapped bits entering bit 0.
// LOAD shifts in an external bit instead of the feedback.
// Assumes TAP_MASK includes bit WIDTH-1 so that the sequence is maximal.
module prpg_lfsr
    import mixbist_pkg::*;
#(
    parameter int               WIDTH      = 32,
    parameter logic [WIDTH-1:0] TAP_MASK   = 32'h8020_0003,
    parameter logic [WIDTH-1:0] RESET_SEED = 32'h1D87_2B41
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pg_op_t           op,
    input  logic             load_bit,
    output logic [WIDTH-1:0] state,
    output logic             ser_out
);
    logic             fb;
    logic [WIDTH-1:0] state_q;

    // Feedback bit from the tapped positions.
    always_comb fb = ^(state_q & TAP_MASK);

    // State register: hold, advance or seed-shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_SEED;
        end else begin
            unique case (op)
                PG_STEP: state_q <= {state_q[WIDTH-2:0], fb};
                PG_LOAD: state_q <= {state_q[WIDTH-2:0], load_bit};
                default: state_q <= state_q;
            endcase
        end
    end

    assign state   = state_q;
    assign ser_out = state_q[WIDTH-1];
endmodule

// File: rtl/step_counter.sv
// Down counter for shift, seed and burst lengths.
// A load takes priority over a decrement. last is high when one step remains.
// Assumes it is never decremented at zero.
module step_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - CW'(1);
    end

    // Flag the final step.
    always_comb last = (cnt_q == CW'(1));
endmodule

// File: rtl/mixbist_seq.sv
// Mixed-mode scan test sequencer. It reads schedule entries in address order and runs:
// pseudorandom patterns, reseeded patterns, generator-only bursts, and end of test.
// Assumes the schedule table answers combinationally and that CHAIN_LEN is at least 1.
// The response stream is only passed through.
module mixbist_seq
    import mixbist_pkg::*;
#(
    parameter int          CHAIN_LEN  = 32,
    parameter int          SCHED_AW   = 4,
    parameter logic [31:0] TAP_MASK   = 32'h8020_0003,
    parameter logic [31:0] RESET_SEED = 32'h1D87_2B41
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [SCHED_AW-1:0] sched_addr,
    input  logic [17:0]         sched_entry,
    input  logic                seed_valid,
    input  logic                seed_bit,
    output logic                seed_ready,
    output logic                scan_en,
    output logic                chain_clk_en,
    output logic                scan_data,
    output logic                capture,
    input  logic                chain_out,
    output logic                resp_out,
    output logic                done
);
    localparam int LEN_W = $clog2(CHAIN_LEN + 1);
    localparam int CW    = (LEN_W > COUNT_FLD_W) ? LEN_W : COUNT_FLD_W;

    seq_state_t          state_q, state_d;
    logic [SCHED_AW-1:0] ptr_q;
    logic                ptr_inc;
    logic                pend_q;
    pg_op_t              pg_op;
    logic [31:0]         pg_state;
    logic                pg_out;
    logic                cnt_load, cnt_dec, cnt_last;
    logic [CW-1:0]       cnt_val;
    ent_kind_t           ent_kind;
    logic [COUNT_FLD_W-1:0] ent_count;

    // Split the schedule entry into its fields.
    always_comb begin
        ent_kind  = ent_kind_t'(sched_entry[17:16]);
        ent_count = sched_entry[COUNT_FLD_W-1:0];
    end

    prpg_lfsr #(
        .WIDTH      (SEED_BITS),
        .TAP_MASK   (TAP_MASK),
        .RESET_SEED (RESET_SEED)
    ) u_prpg (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (pg_op),
        .load_bit (seed_bit),
        .state    (pg_state),
        .ser_out  (pg_out)
    );

    step_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    // Next-state, generator and counter control.
    always_comb begin
        state_d  = state_q;
        pg_op    = PG_HOLD;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        ptr_inc  = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                unique case (ent_kind)
                    ENT_RAND: begin
                        state_d  = ST_SHIFT;
                        cnt_load = 1'b1;
                        cnt_val  = CW'(CHAIN_LEN);
                        ptr_inc  = 1'b1;
                    end
                    ENT_SEED: begin
                        state_d  = ST_SEED;
                        cnt_load = 1'b1;
                        cnt_val  = CW'(SEED_BITS);
                        ptr_inc  = 1'b1;
                    end
                    ENT_PART: begin
                        ptr_inc = 1'b1;
                        if (ent_count != '0) begin
                            state_d  = ST_PART;
                            cnt_load = 1'b1;
                            cnt_val  = CW'(ent_count);
                        end
                    end
                    default: begin
                        if (pend_q) begin
                            state_d  = ST_UNLOAD;
                            cnt_load = 1'b1;
                            cnt_val  = CW'(CHAIN_LEN);
                        end else begin
                            state_d = ST_DONE;
                        end
                    end
                endcase
            end
            ST_SEED: begin
                if (seed_valid) begin
                    pg_op   = PG_LOAD;
                    cnt_dec = 1'b1;
                    if (cnt_last) begin
                        state_d  = ST_SHIFT;
                        cnt_load = 1'b1;
                        cnt_val  = CW'(CHAIN_LEN);
                    end
                end
            end
            ST_SHIFT: begin
                pg_op   = PG_STEP;
                cnt_dec = 1'b1;
                if (cnt_last) state_d = ST_CAPT;
            end
            ST_CAPT: state_d = ST_FETCH;
            ST_PART: begin
                pg_op   = PG_STEP;
                cnt_dec = 1'b1;
                if (cnt_last) state_d = ST_FETCH;
            end
            ST_UNLOAD: begin
                cnt_dec = 1'b1;
                if (cnt_last) state_d = ST_DONE;
            end
            default: state_d = ST_DONE;
        endcase
    end

    // Sequencer state, schedule pointer and pattern-pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            ptr_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ptr_inc)            ptr_q  <= ptr_q + SCHED_AW'(1);
            if (state_q == ST_CAPT) pend_q <= 1'b1;
        end
    end

    // Port decode from the sequencer state.
    always_comb begin
        seed_ready   = (state_q == ST_SEED);
        scan_en      = (state_q == ST_SHIFT) || (state_q == ST_UNLOAD);
        chain_clk_en = scan_en || (state_q == ST_CAPT);
        capture      = (state_q == ST_CAPT);
        done         = (state_q == ST_DONE);
        scan_data    = pg_out;
        resp_out     = chain_out;
        sched_addr   = ptr_q;
    end
endmodule

// File: rtl/mixbist_chk.sv
// Cycle-level protocol checks for mixbist_seq, attached by bind.
// Assumes it sees the top-level ports and the generator state.
module mixbist_chk #(
    parameter int CHAIN_LEN = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        seed_valid,
    input logic        seed_ready,
    input logic        scan_en,
    input logic        chain_clk_en,
    input logic        capture,
    input logic        done,
    input logic [31:0] pg_state
);
    localparam int RUN_W = $clog2(CHAIN_LEN + 2);
    logic [RUN_W-1:0] run_q;

    // Length of the current run of scan-enable cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (scan_en) run_q <= run_q + RUN_W'(1);
        else              run_q <= '0;
    end

    // R3
    capture_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (!scan_en && chain_clk_en));
    // R3
    capture_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);
    // R3
    capture_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (run_q == RUN_W'(CHAIN_LEN)));
    // R9
    shift_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (run_q < RUN_W'(CHAIN_LEN)));
    // R5
    seed_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_ready && !seed_valid) |=> $stable(pg_state));
    // R5
    seed_chain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ready |-> (!scan_en && !chain_clk_en));
    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(scan_en || chain_clk_en || capture || seed_ready));
endmodule

bind mixbist_seq mixbist_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .seed_valid   (seed_valid),
    .seed_ready   (seed_ready),
    .scan_en      (scan_en),
    .chain_clk_en (chain_clk_en),
    .capture      (capture),
    .done         (done),
    .pg_state     (pg_state)
);

// File: tb/tb_mixbist_seq.sv
// Directed bench: one task per scenario, each checking its own results
// against an independent model of the generator.
module tb_mixbist_seq;
    localparam int          CLK_T = 10;
    localparam int          L     = 20;
    localparam logic [31:0] TAPS  = 32'h8020_0003;
    localparam logic [31:0] RSEED = 32'h1D87_2B41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sched_addr;
    logic [17:0] sched_entry;
    logic        seed_valid = 1'b0, seed_bit = 1'b0;
    logic        seed_ready, scan_en, chain_clk_en, scan_data, capture;
    logic        chain_out = 1'b0, resp_out, done;

    logic [17:0] mem [0:15];
    logic [31:0] m;
    int          n_chk = 0, n_err = 0;

    always #(CLK_T/2) clk = ~clk;
    assign sched_entry = mem[sched_addr];

    mixbist_seq #(.CHAIN_LEN(L), .SCHED_AW(4), .TAP_MASK(TAPS), .RESET_SEED(RSEED)) dut (
        .clk(clk), .rst_n(rst_n), .sched_addr(sched_addr), .sched_entry(sched_entry),
        .seed_valid(seed_valid), .seed_bit(seed_bit), .seed_ready(seed_ready),
        .scan_en(scan_en), .chain_clk_en(chain_clk_en), .scan_data(scan_data),
        .capture(capture), .chain_out(chain_out), .resp_out(resp_out), .done(done)
    );

    function automatic logic [31:0] adv(input logic [31:0] s);
        return {s[30:0], ^(s & TAPS)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; seed_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m = RSEED;
    endtask

    // R1, R8: idle outputs and address zero straight after reset.
    task automatic t_reset_state();
        chk(!scan_en && !chain_clk_en && !capture && !seed_ready && !done, "R1", "idle outputs",
            {scan_en, chain_clk_en, capture, seed_ready, done}, 0);
        chk(sched_addr == 4'd0, "R8", "first address", sched_addr, 0);
        chk(scan_data == RSEED[31], "R1", "reset seed top bit", scan_data, RSEED[31]);
    endtask

    // R11: response passthrough.
    task automatic t_resp();
        chain_out = 1'b1; #1;
        chk(resp_out == 1'b1, "R11", "resp high", resp_out, 1);
        chain_out = 1'b0; #1;
        chk(resp_out == 1'b0, "R11", "resp low", resp_out, 0);
    endtask

    // Wait for the first shift cycle; chains must stay still meanwhile (R7).
    task automatic wait_shift(input bit noise, input string req);
        int  guard = 0;
        bit  quiet = 1'b1;
        while (!scan_en && guard < 2000) begin
            if (noise) begin seed_valid = 1'b1; seed_bit = guard[0]; end
            if (chain_clk_en && !capture) quiet = 1'b0;
            @(negedge clk);
            guard++;
        end
        chk(scan_en == 1'b1, req, "shift start", scan_en, 1);
        chk(quiet, "R7", "chains held between patterns", quiet, 1);
    endtask

    // R2, R3: L shift bits from model state m, then one capture cycle.
    task automatic check_shift(input bit noise, input string req);
        int bad = 0;
        logic [31:0] s = m;
        logic got = 1'b0, exp = 1'b0;
        for (int k = 0; k < L; k++) begin
            if (noise) begin seed_valid = 1'b1; seed_bit = ~seed_bit; end
            if (!scan_en || !chain_clk_en || capture || scan_data != s[31]) begin
                if (bad == 0) begin got = scan_data; exp = s[31]; end
                bad++;
            end
            s = adv(s);
            @(negedge clk);
        end
        seed_valid = 1'b0;
        chk(bad == 0, req, "pattern bits (R2)", got, exp);
        chk(capture && !scan_en && chain_clk_en, "R3", "capture frame",
            {capture, scan_en, chain_clk_en}, 3'b101);
        @(negedge clk);
        chk(!capture, "R3", "single capture", capture, 0);
        m = s;
    endtask

    // R4: pseudorandom entry continues from model state (optionally with seed-port noise, R6).
    task automatic t_rand(input bit noise, input string req);
        wait_shift(noise, req);
        check_shift(noise, req);
    endtask

    // R5: serial seed load, MSB first, with an optional stall.
    task automatic t_seed(input logic [31:0] seed, input bit gap);
        int guard = 0;
        logic sd;
        while (!seed_ready && guard < 2000) begin @(negedge clk); guard++; end
        chk(seed_ready, "R5", "seed_ready raised", seed_ready, 1);
        for (int i = 31; i >= 0; i--) begin
            if (gap && i == 15) begin
                seed_valid = 1'b0; sd = scan_data;
                repeat (3) @(negedge clk);
                chk(seed_ready && !scan_en && scan_data == sd, "R5", "stall holds",
                    {seed_ready, scan_en, scan_data}, {1'b1, 1'b0, sd});
            end
            seed_valid = 1'b1; seed_bit = seed[i];
            @(negedge clk);
        end
        seed_valid = 1'b0;
        chk(!seed_ready && scan_en, "R5", "shift right after seed",
            {seed_ready, scan_en}, 2'b01);
        m = seed;
        check_shift(1'b0, "R5");
    endtask

    // R7: generator-only burst advances the model n times.
    task automatic t_part(input int n);
        for (int i = 0; i < n; i++) m = adv(m);
    endtask

    // R9, R10: frozen final unload, then sticky done.
    task automatic t_end();
        int bad = 0;
        wait_shift(1'b0, "R9");
        for (int k = 0; k < L; k++) begin
            if (!scan_en || !chain_clk_en || capture || done || scan_data != m[31]) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R9", "frozen unload", bad, 0);
        chk(done && !scan_en, "R9", "done after unload", {done, scan_en}, 2'b10);
        bad = 0;
        for (int k = 0; k < 6; k++) begin
            seed_valid = 1'b1;
            @(negedge clk);
            if (!done || scan_en || chain_clk_en || capture || seed_ready) bad++;
        end
        seed_valid = 1'b0;
        chk(bad == 0, "R10", "done held quietly", bad, 0);
    endtask

    // R10: end entry first gives done with no shift.
    task automatic t_stop_first();
        bit saw = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (scan_en || capture) saw = 1'b1;
            @(negedge clk);
        end
        chk(!saw && done, "R10", "immediate done", {saw, done}, 2'b01);
    endtask

    initial begin
        #(CLK_T * 50000);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        foreach (mem[i]) mem[i] = {2'b11, 16'd0};
        mem[0] = {2'b00, 16'd0};   // pseudorandom
        mem[1] = {2'b01, 16'd0};   // deterministic A
        mem[2] = {2'b10, 16'd5};   // burst 5
        mem[3] = {2'b00, 16'd0};   // pseudorandom
        mem[4] = {2'b10, 16'd0};   // burst 0
        mem[5] = {2'b00, 16'd0};   // pseudorandom
        mem[6] = {2'b01, 16'd0};   // deterministic B
        mem[7] = {2'b00, 16'd0};   // pseudorandom
        mem[8] = {2'b11, 16'd0};   // end
        t_resp();
        do_reset();
        t_reset_state();
        t_rand(1'b1, "R6");        // R1: from reset seed; noise on seed port
        t_seed(32'hC0DE_5A17, 1'b1);
        t_part(5);
        t_rand(1'b0, "R7");
        t_part(0);
        t_rand(1'b0, "R4");
        t_seed(32'h8000_0001, 1'b0);
        t_rand(1'b0, "R4");
        t_end();
        mem[0] = {2'b11, 16'd0};
        do_reset();
        t_stop_first();
        summary();
    end
endmodule